// File: doc/BRIEF.md
# Dirty-Page Scanout Region Tracker

This block decides which parts of a framebuffer have to be redrawn in a frame. The framebuffer has lines of a fixed 1024 bytes, so each 4 KB memory page holds exactly four display lines. The block keeps one dirty bit per page in a local bit array. Writers set these bits through a mark port, and a single invalidate strobe sets all of them.

When a frame starts, the block walks the pages from the top of the frame downward, one page per step, until the line of the next page reaches the configured frame height. Adjacent dirty pages are merged into one run. Each run is sent as one update request carrying the first line of the run and its line count. Update requests use a valid/ready handshake, and the walk pauses while a request waits. The block also records the lowest and highest dirty page seen in the frame. At the end of the frame it raises one clear request for that span and wipes the flags inside it. A frame started with a pixel depth of zero does no walk at all.

Top module: `dirty_scan_tracker`

## Requirements
- R1: After reset, `updValid`, `clrValid` and `frameDone` are low and every page flag is clean, so a frame run straight after reset produces no update and no clear request.
- R2: Page p covers lines 4p to 4p+3. The walk visits pages 0, 1, 2 and so on while 4p is below `frameHeight` and p is below the page count. A dirty page at or beyond that bound produces nothing and keeps its flag.
- R3: Each maximal run of consecutive dirty pages produces exactly one update, in walk order, with `updLine` = 4 × first page and `updCount` = 4 × number of pages in the run.
- R4: A run still open when the walk stops is flushed as a final update. Its count reaches the end of the last visited page, even if that lies past `frameHeight`.
- R5: While `updValid` is high and `updReady` is low, `updValid`, `updLine` and `updCount` hold steady and the walk does not advance.
- R6: If at least one visited page was dirty, the frame raises `clrValid` for one cycle with `clrFirst` = lowest dirty page and `clrEnd` = highest dirty page + 1 (exclusive), and every flag in that span becomes clean. With no dirty page there is no clear request.
- R7: A mark made during the walk, on a page the walk has already passed, survives into the next frame only if that page lies outside the cleared span.
- R8: `invalidate` sets the flag of every page, so the next full-height frame yields one update covering the whole area and a clear of pages 0 up to the page count.
- R9: A `startFrame` with `pixDepth` = 0 produces only `frameDone`: no update, no clear, and the flags are left unchanged.
- R10: `frameDone` is a one-cycle pulse. It comes exactly one cycle after the clear cycle; the clear cycle has `clrValid` high when the span holds a dirty page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startFrame | input | 1 | Starts a frame walk; has no effect while a walk is busy |
| frameHeight | input | LINE_W | Frame height in lines |
| pixDepth | input | DEPTH_W | Pixel depth; zero skips the walk |
| markValid | input | 1 | Sets the flag of `markPage` |
| markPage | input | PAGE_W | Page index to mark dirty |
| invalidate | input | 1 | Sets every page flag |
| updValid | output | 1 | An update request is presented |
| updReady | input | 1 | The sink accepts the update |
| updLine | output | LINE_W | First line of the update run |
| updCount | output | LINE_W | Number of lines in the run |
| clrValid | output | 1 | One-cycle clear request |
| clrFirst | output | PAGE_W | Lowest dirty page of the frame |
| clrEnd | output | PAGE_W | Highest dirty page plus one |
| frameDone | output | 1 | End-of-frame pulse |

## Verification
The bench builds the tracker with 16 pages, which gives 64 lines, a 5-bit page index and a 7-bit line field. With this size, the last page, a run that touches the bottom edge, and a frame height larger than the whole area (which caps the walk at the page count) can all be reached in a few dozen cycles. An invalidate of the full array can be checked completely in one frame. Holding ready low in the middle of a frame gives a window in which marks land on pages that the walk has already passed, both inside and outside the span that will be cleared.

// File: rtl/dirty_scan_pkg.sv
package dirty_scan_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic frameInit;   // reset page counter, run and span trackers
    logic pageStep;    // current page visited, advance
    logic runOpen;     // current page starts a run
    logic runLatch;    // close run and capture update fields
    logic clearFire;   // wipe flags in the tracked span
  } scan_strobe_t;

  // Status from datapath to control
  typedef struct packed {
    logic scanEnd;
    logic curDirty;
    logic runActive;
    logic spanValid;
  } scan_status_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_EMIT,
    ST_CLEAR,
    ST_DONE
  } scan_state_t;

endpackage

// File: rtl/dirty_flag_array.sv
module dirty_flag_array #(
  parameter int NUM_PAGES = 192,
  parameter int PAGE_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              markValid,
  input  logic [PAGE_W-1:0] markPage,
  input  logic              invalidate,
  input  logic              clearFire,
  input  logic [PAGE_W-1:0] clrFirst,
  input  logic [PAGE_W-1:0] clrEnd,
  input  logic [PAGE_W-1:0] rdPage,
  output logic              rdDirty
);

  logic [NUM_PAGES-1:0] flagBits;

  genvar i;
  generate
    for (i = 0; i < NUM_PAGES; i++) begin : g_flag
      localparam logic [PAGE_W-1:0] IDX = PAGE_W'(i);
      logic setHit;
      logic clrHit;
      assign setHit = invalidate || (markValid && (markPage == IDX));
      assign clrHit = clearFire && (IDX >= clrFirst) && (IDX < clrEnd);
      // A set in the same cycle as a clear wins: the write is newer.
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       flagBits[i] <= 1'b0;
        else if (setHit) flagBits[i] <= 1'b1;
        else if (clrHit) flagBits[i] <= 1'b0;
      end
    end
  endgenerate

  always_comb begin
    rdDirty = 1'b0;
    if (rdPage < PAGE_W'(NUM_PAGES)) rdDirty = flagBits[rdPage];
  end

endmodule

// File: rtl/dirty_scan_dp.sv
module dirty_scan_dp
  import dirty_scan_pkg::*;
#(
  parameter int NUM_PAGES      = 192,
  parameter int LINES_PER_PAGE = 4,
  parameter int PAGE_W         = 8,
  parameter int LINE_W         = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  scan_strobe_t      strobe,
  input  logic [LINE_W-1:0] frameHeight,
  input  logic              flagDirty,
  output logic [PAGE_W-1:0] scanPage,
  output scan_status_t      status,
  output logic [LINE_W-1:0] updLine,
  output logic [LINE_W-1:0] updCount,
  output logic [PAGE_W-1:0] clrFirst,
  output logic [PAGE_W-1:0] clrEnd
);

  localparam int LPP_SH = $clog2(LINES_PER_PAGE);

  logic [PAGE_W-1:0] pageCnt;
  logic [PAGE_W-1:0] runStart;
  logic              runActive;
  logic [PAGE_W-1:0] minPage;
  logic [PAGE_W-1:0] maxPage;
  logic [LINE_W-1:0] lineOfPage;
  logic [PAGE_W-1:0] runPages;

  assign lineOfPage = LINE_W'(pageCnt) << LPP_SH;
  assign runPages   = pageCnt - runStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageCnt   <= '0;
      runStart  <= '0;
      runActive <= 1'b0;
      minPage   <= '1;
      maxPage   <= '0;
      updLine   <= '0;
      updCount  <= '0;
    end else begin
      if (strobe.frameInit) begin
        pageCnt   <= '0;
        runActive <= 1'b0;
        minPage   <= '1;
        maxPage   <= '0;
      end else begin
        if (strobe.pageStep) begin
          pageCnt <= pageCnt + 1'b1;
          if (flagDirty) begin
            if (pageCnt < minPage) minPage <= pageCnt;
            if (pageCnt > maxPage) maxPage <= pageCnt;
          end
        end
        if (strobe.runOpen) begin
          runStart  <= pageCnt;
          runActive <= 1'b1;
        end
        if (strobe.runLatch) begin
          runActive <= 1'b0;
          updLine   <= LINE_W'(runStart) << LPP_SH;
          updCount  <= LINE_W'(runPages) << LPP_SH;
        end
      end
    end
  end

  assign scanPage         = pageCnt;
  assign clrFirst         = minPage;
  assign clrEnd           = maxPage + 1'b1;
  assign status.scanEnd   = (pageCnt >= PAGE_W'(NUM_PAGES)) || (lineOfPage >= frameHeight);
  assign status.curDirty  = flagDirty;
  assign status.runActive = runActive;
  assign status.spanValid = (minPage <= maxPage);

endmodule

// File: rtl/dirty_scan_ctrl.sv
module dirty_scan_ctrl
  import dirty_scan_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startFrame,
  input  logic         depthZero,
  input  logic         updReady,
  input  scan_status_t status,
  output scan_strobe_t strobe,
  output logic         updValid,
  output logic         clrValid,
  output logic         frameDone
);

  scan_state_t state;
  scan_state_t stateNext;
  logic        finalPending;
  logic        finalSet;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    finalSet  = 1'b0;
    updValid  = 1'b0;
    clrValid  = 1'b0;
    frameDone = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startFrame) begin
          strobe.frameInit = 1'b1;
          stateNext = depthZero ? ST_DONE : ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (status.scanEnd) begin
          if (status.runActive) begin
            strobe.runLatch = 1'b1;
            finalSet  = 1'b1;
            stateNext = ST_EMIT;
          end else begin
            stateNext = ST_CLEAR;
          end
        end else begin
          strobe.pageStep = 1'b1;
          if (status.curDirty && !status.runActive) strobe.runOpen = 1'b1;
          if (!status.curDirty && status.runActive) begin
            strobe.runLatch = 1'b1;
            stateNext = ST_EMIT;
          end
        end
      end
      ST_EMIT: begin
        updValid = 1'b1;
        if (updReady) stateNext = finalPending ? ST_CLEAR : ST_SCAN;
      end
      ST_CLEAR: begin
        clrValid         = status.spanValid;
        strobe.clearFire = status.spanValid;
        stateNext        = ST_DONE;
      end
      ST_DONE: begin
        frameDone = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      finalPending <= 1'b0;
    end else begin
      state <= stateNext;
      if (strobe.frameInit) finalPending <= 1'b0;
      else if (finalSet)    finalPending <= 1'b1;
    end
  end

endmodule

// File: rtl/dirty_scan_tracker.sv
module dirty_scan_tracker
  import dirty_scan_pkg::*;
#(
  parameter int NUM_PAGES  = 192,
  parameter int LINE_BYTES = 1024,
  parameter int PAGE_BYTES = 4096,
  parameter int DEPTH_W    = 6,
  parameter int PAGE_W     = $clog2(NUM_PAGES + 1),
  parameter int LINE_W     = PAGE_W + $clog2(PAGE_BYTES / LINE_BYTES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startFrame,
  input  logic [LINE_W-1:0]  frameHeight,
  input  logic [DEPTH_W-1:0] pixDepth,
  input  logic               markValid,
  input  logic [PAGE_W-1:0]  markPage,
  input  logic               invalidate,
  output logic               updValid,
  input  logic               updReady,
  output logic [LINE_W-1:0]  updLine,
  output logic [LINE_W-1:0]  updCount,
  output logic               clrValid,
  output logic [PAGE_W-1:0]  clrFirst,
  output logic [PAGE_W-1:0]  clrEnd,
  output logic               frameDone
);

  localparam int LINES_PER_PAGE = PAGE_BYTES / LINE_BYTES;

  scan_strobe_t      strobe;
  scan_status_t      status;
  logic [PAGE_W-1:0] scanPage;
  logic              flagDirty;

  dirty_flag_array #(
    .NUM_PAGES(NUM_PAGES),
    .PAGE_W   (PAGE_W)
  ) u_flags (
    .clk       (clk),
    .rstN      (rstN),
    .markValid (markValid),
    .markPage  (markPage),
    .invalidate(invalidate),
    .clearFire (strobe.clearFire),
    .clrFirst  (clrFirst),
    .clrEnd    (clrEnd),
    .rdPage    (scanPage),
    .rdDirty   (flagDirty)
  );

  dirty_scan_dp #(
    .NUM_PAGES     (NUM_PAGES),
    .LINES_PER_PAGE(LINES_PER_PAGE),
    .PAGE_W        (PAGE_W),
    .LINE_W        (LINE_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .frameHeight(frameHeight),
    .flagDirty  (flagDirty),
    .scanPage   (scanPage),
    .status     (status),
    .updLine    (updLine),
    .updCount   (updCount),
    .clrFirst   (clrFirst),
    .clrEnd     (clrEnd)
  );

  dirty_scan_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startFrame(startFrame),
    .depthZero (pixDepth == '0),
    .updReady  (updReady),
    .status    (status),
    .strobe    (strobe),
    .updValid  (updValid),
    .clrValid  (clrValid),
    .frameDone (frameDone)
  );

endmodule

// File: rtl/dirty_scan_checker.sv
module dirty_scan_checker #(
  parameter int NUM_PAGES      = 192,
  parameter int LINES_PER_PAGE = 4,
  parameter int PAGE_W         = 8,
  parameter int LINE_W         = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              updValid,
  input logic              updReady,
  input logic [LINE_W-1:0] updLine,
  input logic [LINE_W-1:0] updCount,
  input logic              clrValid,
  input logic [PAGE_W-1:0] clrFirst,
  input logic [PAGE_W-1:0] clrEnd,
  input logic              frameDone
);

  localparam int AREA_LINES = NUM_PAGES * LINES_PER_PAGE;

  p_upd_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && !updReady) |=> (updValid && $stable(updLine) && $stable(updCount)));

  p_upd_shape_r3: assert property (@(posedge clk) disable iff (!rstN)
    updValid |-> ((updCount != '0) && ((updCount % LINE_W'(LINES_PER_PAGE)) == '0)
                  && ((updLine % LINE_W'(LINES_PER_PAGE)) == '0)));

  p_upd_inside_r2: assert property (@(posedge clk) disable iff (!rstN)
    updValid |-> ((32'(updLine) + 32'(updCount)) <= 32'(AREA_LINES)));

  p_clr_span_r6: assert property (@(posedge clk) disable iff (!rstN)
    clrValid |-> ((clrFirst < clrEnd) && (32'(clrEnd) <= 32'(NUM_PAGES))));

  p_clr_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(clrValid && updValid));

  p_clr_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    clrValid |=> frameDone);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

endmodule

bind dirty_scan_tracker dirty_scan_checker #(
  .NUM_PAGES     (NUM_PAGES),
  .LINES_PER_PAGE(PAGE_BYTES / LINE_BYTES),
  .PAGE_W        (PAGE_W),
  .LINE_W        (LINE_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .updValid (updValid),
  .updReady (updReady),
  .updLine  (updLine),
  .updCount (updCount),
  .clrValid (clrValid),
  .clrFirst (clrFirst),
  .clrEnd   (clrEnd),
  .frameDone(frameDone)
);

// File: tb/dirty_scan_tracker_tb.sv
module dirty_scan_tracker_tb;

  localparam int NP     = 16;
  localparam int PW     = 5;
  localparam int LW     = 7;
  localparam int DW     = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startFrame = 1'b0;
  logic [LW-1:0] frameHeight = '0;
  logic [DW-1:0] pixDepth = 6'd8;
  logic          markValid = 1'b0;
  logic [PW-1:0] markPage = '0;
  logic          invalidate = 1'b0;
  logic          updValid;
  logic          updReady = 1'b1;
  logic [LW-1:0] updLine;
  logic [LW-1:0] updCount;
  logic          clrValid;
  logic [PW-1:0] clrFirst;
  logic [PW-1:0] clrEnd;
  logic          frameDone;

  dirty_scan_tracker #(.NUM_PAGES(NP), .DEPTH_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .startFrame(startFrame), .frameHeight(frameHeight),
    .pixDepth(pixDepth), .markValid(markValid), .markPage(markPage),
    .invalidate(invalidate), .updValid(updValid), .updReady(updReady),
    .updLine(updLine), .updCount(updCount), .clrValid(clrValid),
    .clrFirst(clrFirst), .clrEnd(clrEnd), .frameDone(frameDone)
  );

  always #5 clk = ~clk;

  int cycle = 0;
  int nChecks = 0;
  int nFails = 0;
  always @(posedge clk) cycle <= cycle + 1;

  // Recorded traffic of the current frame
  int updN = 0;
  int updLineQ [32];
  int updCntQ  [32];
  int clrN = 0;
  int clrF = 0;
  int clrE = 0;
  int clrCyc = 0;
  int doneCyc = 0;
  bit doneSeen = 1'b0;
  int stallSeen = 0;
  int stallFails = 0;
  bit prevStall = 1'b0;
  int prevLine = 0;
  int prevCnt = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (prevStall) begin
        if (!updValid || int'(updLine) != prevLine || int'(updCount) != prevCnt)
          stallFails++;
      end
      prevStall = updValid && !updReady;
      if (prevStall) begin
        stallSeen++;
        prevLine = int'(updLine);
        prevCnt  = int'(updCount);
      end
      if (updValid && updReady && updN < 32) begin
        updLineQ[updN] = int'(updLine);
        updCntQ[updN]  = int'(updCount);
        updN++;
      end
      if (clrValid) begin
        clrN++;
        clrF = int'(clrFirst);
        clrE = int'(clrEnd);
        clrCyc = cycle;
      end
      if (frameDone) begin
        doneSeen = 1'b1;
        doneCyc = cycle;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic mark(input int p);
    markValid = 1'b1;
    markPage  = PW'(p);
    tick();
    markValid = 1'b0;
  endtask

  task automatic clearRecord();
    updN = 0;
    clrN = 0;
    doneSeen = 1'b0;
  endtask

  task automatic launch(input int h, input int d);
    clearRecord();
    frameHeight = LW'(h);
    pixDepth    = DW'(d);
    startFrame  = 1'b1;
    tick();
    startFrame  = 1'b0;
  endtask

  task automatic waitDone();
    int n = 0;
    while (!doneSeen && n < 2000) begin
      tick();
      n++;
    end
    chk(doneSeen, "frame completes (R10)", int'(doneSeen), 1);
    tick();
  endtask

  task automatic runFrame(input int h, input int d);
    launch(h, d);
    waitDone();
  endtask

  task automatic expUpd(input int k, input int ln, input int cnt, input string tag);
    chk(updLineQ[k] == ln, {tag, " line"}, updLineQ[k], ln);
    chk(updCntQ[k] == cnt, {tag, " count"}, updCntQ[k], cnt);
  endtask

  // R1: reset state
  task automatic t_reset();
    @(negedge clk);
    chk(!updValid && !clrValid && !frameDone, "R1 outputs idle after reset",
        int'({updValid, clrValid, frameDone}), 0);
    runFrame(64, 8);
    chk(updN == 0, "R1 no update after reset", updN, 0);
    chk(clrN == 0, "R1 no clear after reset", clrN, 0);
  endtask

  // R3, R6, R10: several runs in one frame
  task automatic t_runs();
    mark(1); mark(2); mark(4); mark(6); mark(7); mark(8);
    runFrame(64, 8);
    chk(updN == 3, "R3 run count", updN, 3);
    expUpd(0, 4, 8, "R3 run0");
    expUpd(1, 16, 4, "R3 run1");
    expUpd(2, 24, 12, "R3 run2");
    chk(clrN == 1, "R6 one clear", clrN, 1);
    chk(clrF == 1, "R6 clear first", clrF, 1);
    chk(clrE == 9, "R6 clear end", clrE, 9);
    chk(doneCyc == clrCyc + 1, "R10 done after clear", doneCyc - clrCyc, 1);
    runFrame(64, 8);
    chk(updN == 0, "R6 flags wiped", updN, 0);
    chk(clrN == 0, "R6 no clear on clean frame", clrN, 0);
  endtask

  // R4: open run flushed at end
  task automatic t_flush();
    mark(14); mark(15);
    runFrame(64, 8);
    chk(updN == 1, "R4 bottom run count", updN, 1);
    expUpd(0, 56, 8, "R4 bottom run");
    chk(clrF == 14 && clrE == 16, "R4 bottom clear end", clrE, 16);
    mark(1); mark(2);
    runFrame(10, 8);
    chk(updN == 1, "R4 short frame count", updN, 1);
    expUpd(0, 4, 8, "R4 flush past height");
    chk(clrE == 3, "R4 short frame clear end", clrE, 3);
  endtask

  // R2: pages beyond the height are untouched
  task automatic t_height();
    mark(2);
    runFrame(8, 8);
    chk(updN == 0, "R2 page past height unseen", updN, 0);
    chk(clrN == 0, "R2 no clear past height", clrN, 0);
    runFrame(12, 8);
    chk(updN == 1, "R2 flag kept", updN, 1);
    expUpd(0, 8, 4, "R2 later frame");
  endtask

  // R5, R7: stall and marks behind the walk
  task automatic t_stall();
    int n = 0;
    mark(2); mark(3); mark(6);
    updReady = 1'b0;
    launch(64, 8);
    while (!updValid && n < 200) begin
      tick();
      n++;
    end
    tick(); tick(); tick();
    chk(updValid && int'(updLine) == 8, "R5 held while not ready", int'(updLine), 8);
    mark(1);
    mark(3);
    updReady = 1'b1;
    waitDone();
    chk(stallSeen > 0 && stallFails == 0, "R5 stable during stall", stallFails, 0);
    chk(updN == 2, "R5 updates after stall", updN, 2);
    expUpd(0, 8, 8, "R5 run0");
    expUpd(1, 24, 4, "R5 run1");
    chk(clrF == 2 && clrE == 7, "R7 span", clrE, 7);
    runFrame(64, 8);
    chk(updN == 1, "R7 only outside mark survives", updN, 1);
    expUpd(0, 4, 4, "R7 survivor");
    chk(clrF == 1 && clrE == 2, "R7 survivor clear", clrF, 1);
  endtask

  // R8: invalidate
  task automatic t_inval();
    invalidate = 1'b1;
    tick();
    invalidate = 1'b0;
    runFrame(100, 8);
    chk(updN == 1, "R8 single full update", updN, 1);
    expUpd(0, 0, 64, "R8 full area");
    chk(clrF == 0 && clrE == 16, "R8 full clear", clrE, 16);
    runFrame(64, 8);
    chk(updN == 0, "R8 clean afterwards", updN, 0);
  endtask

  // R9: depth zero
  task automatic t_depth();
    mark(5);
    runFrame(64, 0);
    chk(updN == 0, "R9 no update at depth 0", updN, 0);
    chk(clrN == 0, "R9 no clear at depth 0", clrN, 0);
    runFrame(64, 8);
    chk(updN == 1, "R9 flag kept", updN, 1);
    expUpd(0, 20, 4, "R9 later frame");
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    t_reset();
    t_runs();
    t_flush();
    t_height();
    t_stall();
    t_inval();
    t_depth();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #1000000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cycle);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule